// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial characters and hands each one to a one-deep holding buffer. It runs from the system clock and advances only on a 16x oversampling enable. The serial input first passes through a small synchronizer. A falling edge starts a candidate frame, and the block confirms the start bit at its midpoint. It then samples every later bit at its centre: five to eight data bits, least significant first, an optional parity bit, and one or two stop bits.

When the last stop bit has been sampled, the character is complete. The block decides whether to write it into the buffer, and it raises one-cycle status pulses for overrun, framing error, parity error and break. A break is a frame in which every sampled bit is zero, including the parity and stop bits. A break still counts as a received character. The host reads a character by pulsing a read strobe, which clears the data-ready indication.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, `data_rdy`, `rx_data` and all four status pulses are zero.
- R2: Data bits are captured least significant bit first. The number of bits is set by `wlen` as 5 + `wlen`: code 0 gives 5 bits and code 3 gives 8 bits. Unused upper bits of `rx_data` read as zero.
- R3: A low level starts a frame only if the line is still low at the sample taken 8 enable ticks after the low was first seen. If the line is high at that sample, nothing is loaded and no status pulse appears.
- R4: When `par_en` is 1, a parity bit follows the data. `par_odd` = 0 selects even parity and 1 selects odd parity. `err_par` pulses when the XOR of the data bits and the parity bit differs from `par_odd`.
- R5: `err_frm` pulses when any required stop bit is low at its centre sample. This includes a stop bit that went high but fell again before its centre. `stop2` = 1 requires two stop bits.
- R6: An all-zero frame pulses `brk_det` together with `err_frm`. It still loads `rx_data` with zero and sets `data_rdy`.
- R7: If a character completes while `data_rdy` is 1 and `rd_stb` is low, `err_ovr` pulses. The new character is discarded, and `rx_data` and `data_rdy` keep their values.
- R8: `rd_stb` while `data_rdy` is 1, with no character completing in that cycle, clears `data_rdy` on the next cycle.
- R9: If `rd_stb` and the completion of a character fall in the same cycle, the new character is loaded, `data_rdy` stays 1 and no overrun is reported.
- R10: Status pulses last exactly one clock cycle. They appear in the cycle after completion, which is the same cycle in which a loaded character first shows on `data_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial input line, idle high |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| wlen | input | 2 | Word length code, bits = 5 + code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop2 | input | 1 | Two stop bits required |
| rd_stb | input | 1 | Buffer read strobe |
| rx_data | output | 8 | Buffered character |
| data_rdy | output | 1 | Buffer holds an unread character |
| err_ovr | output | 1 | Overrun pulse |
| err_frm | output | 1 | Framing error pulse |
| err_par | output | 1 | Parity error pulse |
| brk_det | output | 1 | Break pulse |

## Verification
Two functions can land on the same clock edge: the host read of the buffer and the load of a newly completed character. The bench makes this happen by raising `rd_stb` together with the enable tick on which the final stop bit is sampled. It judges the result by checking three things: the new character is in `rx_data`, `data_rdy` is still set, and no overrun pulse was counted. A second scenario leaves the read out of the same situation and expects the overrun pulse with the old character kept.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_t;

  // number of data bits for a word length code
  function automatic int unsigned word_bits(input logic [1:0] code);
    return 32'd5 + {30'd0, code};
  endfunction

  // 1 when received data plus parity disagree with the programmed sense
  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic p, input logic odd);
    return (^d) ^ p ^ odd;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              stop2,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              pbit,
  output logic              stop_bad,
  output logic              any_one
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(DATA_W);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic              pb, sbad, one;
  logic              at_sample, last_stop, last_bit;

  assign at_sample = tick && ((st == ST_START) ? (cnt == CW'(HALF - 1))
                                               : (cnt == CW'(OSR - 1)));
  assign last_stop = (st == ST_STOP1 && !stop2) || (st == ST_STOP2);
  assign last_bit  = ({{(32-BW){1'b0}}, bidx} == word_bits(wlen) - 32'd1);

  assign done     = at_sample && last_stop;
  assign data     = sh;
  assign pbit     = pb;
  assign stop_bad = sbad | ~rx;
  assign any_one  = one | rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      pb   <= 1'b0;
      sbad <= 1'b0;
      one  <= 1'b0;
    end else if (tick) begin
      if (st == ST_IDLE) begin
        if (!rx) begin
          st   <= ST_START;
          cnt  <= '0;
          bidx <= '0;
          sh   <= '0;
          pb   <= 1'b0;
          sbad <= 1'b0;
          one  <= 1'b0;
        end
      end else if (!at_sample) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (st)
          ST_START: st <= rx ? ST_IDLE : ST_DATA;
          ST_DATA: begin
            sh[bidx] <= rx;
            one      <= one | rx;
            if (last_bit) st <= par_en ? ST_PAR : ST_STOP1;
            else          bidx <= bidx + 1'b1;
          end
          ST_PAR: begin
            pb  <= rx;
            one <= one | rx;
            st  <= ST_STOP1;
          end
          ST_STOP1: begin
            sbad <= ~rx;
            one  <= one | rx;
            st   <= stop2 ? ST_STOP2 : ST_IDLE;
          end
          ST_STOP2: st <= ST_IDLE;
          default:  st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] din,
  input  logic              pbit,
  input  logic              stop_bad,
  input  logic              any_one,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_rdy,
  output logic              err_ovr,
  output logic              err_frm,
  output logic              err_par,
  output logic              brk_det
);
  logic load;
  assign load = done && (!data_rdy || rd_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      data_rdy <= 1'b0;
      err_ovr  <= 1'b0;
      err_frm  <= 1'b0;
      err_par  <= 1'b0;
      brk_det  <= 1'b0;
    end else begin
      if (load) rx_data <= din;
      if (load)        data_rdy <= 1'b1;
      else if (rd_stb) data_rdy <= 1'b0;
      err_ovr <= done && data_rdy && !rd_stb;
      err_frm <= done && stop_bad;
      err_par <= done && par_en && parity_bad(din, pbit, par_odd);
      brk_det <= done && !any_one;
    end
  end
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              tick16,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_rdy,
  output logic              err_ovr,
  output logic              err_frm,
  output logic              err_par,
  output logic              brk_det
);
  logic              rx_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_pbit, frame_sbad, frame_one;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
    .wlen(wlen), .par_en(par_en), .stop2(stop2),
    .done(frame_done), .data(frame_data), .pbit(frame_pbit),
    .stop_bad(frame_sbad), .any_one(frame_one)
  );

  uart_rx_buf u_buf (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .din(frame_data),
    .pbit(frame_pbit), .stop_bad(frame_sbad), .any_one(frame_one),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
    .rx_data(rx_data), .data_rdy(data_rdy), .err_ovr(err_ovr),
    .err_frm(err_frm), .err_par(err_par), .brk_det(brk_det)
  );
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_done,
  input logic       rd_stb,
  input logic [7:0] rx_data,
  input logic       data_rdy,
  input logic       err_ovr,
  input logic       err_frm,
  input logic       err_par,
  input logic       brk_det
);
  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && data_rdy && !rd_stb |=> err_ovr);

  a_r7_old_kept: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && data_rdy && !rd_stb |=> $stable(rx_data) && data_rdy);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && data_rdy && !frame_done |=> !data_rdy);

  a_r9_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && (!data_rdy || rd_stb) |=> data_rdy && !err_ovr);

  a_r6_break_frames: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> err_frm && data_rdy);

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr || err_frm || err_par || brk_det) |=>
      !(err_ovr || err_frm || err_par || brk_det));
endmodule

bind uart_rx_brk uart_rx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .rd_stb(rd_stb),
  .rx_data(rx_data), .data_rdy(data_rdy), .err_ovr(err_ovr),
  .err_frm(err_frm), .err_par(err_par), .brk_det(brk_det)
);

// File: tb/uart_rx_brk_tb.sv
module uart_rx_brk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, rd_stb = 1'b0;
  logic [7:0] rx_data;
  logic       data_rdy, err_ovr, err_frm, err_par, brk_det;

  int n_chk = 0, n_bad = 0;
  int c_ovr = 0, c_frm = 0, c_par = 0, c_brk = 0;
  int b_ovr, b_frm, b_par, b_brk;

  always #10 clk = ~clk;

  uart_rx_brk u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
    .wlen(wlen), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .rd_stb(rd_stb), .rx_data(rx_data), .data_rdy(data_rdy),
    .err_ovr(err_ovr), .err_frm(err_frm), .err_par(err_par),
    .brk_det(brk_det)
  );

  always @(posedge clk) begin
    if (err_ovr) c_ovr++;
    if (err_frm) c_frm++;
    if (err_par) c_par++;
    if (brk_det) c_brk++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one oversampling period: 4 clocks, tick on the third
  task automatic slot(input logic v, input logic rd);
    rx_in = v;
    @(negedge clk);
    @(negedge clk);
    tick16 = 1'b1; rd_stb = rd;
    @(negedge clk);
    tick16 = 1'b0; rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic mark_counts();
    b_ovr = c_ovr; b_frm = c_frm; b_par = c_par; b_brk = c_brk;
  endtask

  // kind: 0 good, 1 wrong parity, 2 short last stop, 3 all zero
  task automatic send(input logic [7:0] d, input int kind, input logic rd_end);
    logic bits [0:12];
    int nb, n, last;
    nb = 5 + int'(wlen);
    n = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = d[i];
    if (par_en) begin
      logic p;
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      p ^= par_odd;
      bits[n++] = (kind == 1) ? ~p : p;
    end
    bits[n++] = 1'b1;
    if (stop2) bits[n++] = 1'b1;
    if (kind == 3) for (int i = 0; i < n; i++) bits[i] = 1'b0;
    last = 8 + 16 * (n - 1);
    mark_counts();
    for (int t = 0; t < 16 * n; t++) begin
      logic v;
      v = bits[t / 16];
      if (kind == 2 && t / 16 == n - 1 && t % 16 >= 4) v = 1'b0;
      slot(v, rd_end && t == last);
    end
    for (int t = 0; t < 20; t++) slot(1'b1, 1'b0);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    check("R8 data_rdy cleared by read", int'(data_rdy), 0);
  endtask

  task automatic flags(input string tag, input int o, input int f,
                       input int p, input int b);
    check({tag, " overrun"}, c_ovr - b_ovr, o);
    check({tag, " framing"}, c_frm - b_frm, f);
    check({tag, " parity"},  c_par - b_par, p);
    check({tag, " break"},   c_brk - b_brk, b);
  endtask

  task automatic t_reset();
    check("R1 data_rdy", int'(data_rdy), 0);
    check("R1 rx_data", int'(rx_data), 0);
    check("R1 pulses", int'({err_ovr, err_frm, err_par, brk_det}), 0);
  endtask

  task automatic t_basic();
    wlen = 2'd3; par_en = 0; stop2 = 0;
    send(8'hA5, 0, 1'b0);
    check("R2 8-bit data", int'(rx_data), 'hA5);
    check("R2 ready", int'(data_rdy), 1);
    flags("R2", 0, 0, 0, 0);
    do_read();
    wlen = 2'd0; par_en = 1; par_odd = 0;
    send(8'hF3, 0, 1'b0);
    check("R2 5-bit data upper zero", int'(rx_data), 'h13);
    flags("R4 even good", 0, 0, 0, 0);
    do_read();
    wlen = 2'd1; par_en = 0;
    send(8'hFF, 0, 1'b0);
    check("R2 6-bit data", int'(rx_data), 'h3F);
    do_read();
  endtask

  task automatic t_parity();
    wlen = 2'd2; par_en = 1; par_odd = 1;
    send(8'h5A, 0, 1'b0);
    check("R4 7-bit odd good data", int'(rx_data), 'h5A);
    flags("R4 odd good", 0, 0, 0, 0);
    do_read();
    send(8'h2C, 1, 1'b0);
    flags("R4 odd wrong", 0, 0, 1, 0);
    check("R4 data still loaded", int'(rx_data), 'h2C);
    do_read();
    par_en = 0;
  endtask

  task automatic t_framing();
    wlen = 2'd3; stop2 = 0;
    send(8'h96, 2, 1'b0);
    flags("R5 short stop", 0, 1, 0, 0);
    check("R5 data loaded", int'(rx_data), 'h96);
    do_read();
    stop2 = 1;
    send(8'h69, 0, 1'b0);
    flags("R5 two stops good", 0, 0, 0, 0);
    do_read();
    send(8'h69, 2, 1'b0);
    flags("R5 second stop short", 0, 1, 0, 0);
    do_read();
    stop2 = 0;
  endtask

  task automatic t_break();
    wlen = 2'd3; par_en = 1; par_odd = 0;
    send(8'h00, 3, 1'b0);
    flags("R6 break", 0, 1, 0, 1);
    check("R6 data zero", int'(rx_data), 0);
    check("R6 ready", int'(data_rdy), 1);
    do_read();
    par_en = 0;
  endtask

  task automatic t_false_start();
    mark_counts();
    for (int t = 0; t < 5; t++) slot(1'b0, 1'b0);
    for (int t = 0; t < 40; t++) slot(1'b1, 1'b0);
    check("R3 false start no data", int'(data_rdy), 0);
    flags("R3 false start", 0, 0, 0, 0);
  endtask

  task automatic t_overrun();
    wlen = 2'd3;
    send(8'h11, 0, 1'b0);
    send(8'h22, 0, 1'b0);
    flags("R7 overrun", 1, 0, 0, 0);
    check("R7 old data kept", int'(rx_data), 'h11);
    check("R7 still ready", int'(data_rdy), 1);
    do_read();
  endtask

  task automatic t_collide();
    send(8'h33, 0, 1'b0);
    send(8'h44, 0, 1'b1);
    flags("R9 read at completion", 0, 0, 0, 0);
    check("R9 new data", int'(rx_data), 'h44);
    check("R9 ready", int'(data_rdy), 1);
    do_read();
  endtask

  task automatic t_pulse();
    int hi;
    send(8'h7E, 2, 1'b0);
    hi = 0;
    @(negedge clk);
    check("R10 pulse count one", c_frm - b_frm, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (err_frm) hi++;
    end
    check("R10 pulse gone", hi, 0);
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_framing();
    t_break();
    t_false_start();
    t_overrun();
    t_collide();
    t_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule